// File: doc/BRIEF.md
# Chunked SRAM Staging Controller

This block parks one chunk of software input data in an external quad-data-rate SRAM and then replays it to the user logic. The input FIFO therefore never fills up while the user logic is still busy with the previous chunk. Software first writes the chunk length in bytes into a configuration register. The controller then accepts ceil(bytes/16) 128-bit words from the input stream. It widens each word to a zero-padded 144-bit memory word and writes it at ascending word addresses starting from zero.

Once the last word is stored, the controller reads the same addresses back in order. It strips the padding and streams the 128-bit words out with a valid/ready handshake. Read data arrives a fixed number of cycles after each request. Requests are throttled by credit so that returning data always has space in a small skid buffer, even when the output is stalled.

After the final word is handed over, the controller raises a one-cycle done pulse and returns to idle, where it will take the next chunk. Keep-alive dummy register writes can arrive at any time. They are acknowledged, but they reach neither the memory nor the chunk counters.

Top module: `chunk_stage_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, idle_o is 1 and in_ready_o, out_valid_o, mem_wr_en_o, mem_rd_en_o, done_o and dummy_ack_o are all 0.
- R2: In idle, a write with cfg_we_i=1 and a non-zero cfg_bytes_i starts a chunk of ceil(cfg_bytes_i/16) words. idle_o falls and in_ready_o rises in the next cycle.
- R3: Each accepted input word (in_valid_i and in_ready_o both 1) is written to memory in the same cycle. Addresses start at 0 for each chunk and increase by 1. Memory beat b occupies bits [36b+35:36b] and holds input bits [32b+31:32b] in its low 32 bits, with its top 4 bits zero.
- R4: After exactly the chunk's word count has been accepted, in_ready_o is 0 from the next cycle. No further memory write happens until a new chunk starts.
- R5: The stored words are read at addresses 0 to N-1 in ascending order, exactly N reads per chunk, and never in the same cycle as a write. Read data is taken from mem_rd_data_i RD_LAT cycles after the request cycle.
- R6: Output word slice [32b+31:32b] equals bits [36b+31:36b] of the memory word, whatever the pad bits hold. Output words appear in address order.
- R7: When out_ready_i is 0, out_valid_o and out_data_o hold. No word is lost or repeated. Issued reads never exceed delivered words by more than RD_LAT+2.
- R8: done_o is 1 for exactly one cycle, in the cycle after the final output handshake. idle_o is 1 in the cycle after that.
- R9: dummy_we_i in any state gives dummy_ack_o=1 in the next cycle. It causes no memory access and does not change the word counts.
- R10: cfg_we_i is ignored outside idle, and in idle when cfg_bytes_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Byte-count register write strobe |
| cfg_bytes_i | input | ADDR_W+4 | Chunk length in bytes |
| dummy_we_i | input | 1 | Keep-alive dummy register write |
| dummy_ack_o | output | 1 | Acknowledge of a dummy write |
| idle_o | output | 1 | Ready to accept a new chunk |
| done_o | output | 1 | Pulse after the last word of the chunk |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | DATA_W | Input word |
| in_ready_o | output | 1 | Input word accepted |
| mem_wr_en_o | output | 1 | Memory write request |
| mem_wr_addr_o | output | ADDR_W | Memory write word address |
| mem_wr_data_o | output | MEM_W | Padded memory write word |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_rd_addr_o | output | ADDR_W | Memory read word address |
| mem_rd_data_i | input | MEM_W | Memory read word, RD_LAT cycles after request |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | DATA_W | Output word |
| out_ready_i | input | 1 | Output consumer ready |

## Verification
Keep-alive acknowledges and chunk progress can fall in the same cycle. The bench pulses dummy_we_i in the same cycle as a mid-chunk input handshake, and again during a long output stall while reads are in flight. It judges the result by the next-cycle acknowledge, by an unchanged write and read count, and by the exact address sequence. A second coincidence is a byte-count write landing on an input handshake in FILL. It must leave the chunk length as it was, which shows as in_ready_o dropping after the original word count.

// File: rtl/chunk_stage_pkg.sv
package chunk_stage_pkg;
  localparam int SLICE_W = 32;
  localparam int BEAT_W  = 36;
  localparam int PAD_W   = BEAT_W - SLICE_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } cs_state_e;
endpackage

// File: rtl/cs_write_path.sv
module cs_write_path import chunk_stage_pkg::*; #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = ADDR_W + 1,
  localparam int BEATS = DATA_W / SLICE_W,
  localparam int MEM_W = BEATS * BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fill_i,
  input  logic [CNT_W-1:0]  target_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              mem_wr_en_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [MEM_W-1:0]  mem_wr_data_o,
  output logic              last_o
);
  logic [CNT_W-1:0] wr_cnt_q;
  logic             fire;

  assign in_ready_o    = fill_i;
  assign fire          = fill_i && in_valid_i;
  assign mem_wr_en_o   = fire;
  assign mem_wr_addr_o = wr_cnt_q[ADDR_W-1:0];
  assign last_o        = fire && (wr_cnt_q == target_i - CNT_W'(1));

  for (genvar b = 0; b < BEATS; b++) begin : g_pad
    assign mem_wr_data_o[b*BEAT_W +: BEAT_W] =
      {{PAD_W{1'b0}}, in_data_i[b*SLICE_W +: SLICE_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wr_cnt_q <= '0;
    else if (start_i) wr_cnt_q <= '0;
    else if (fire)    wr_cnt_q <= wr_cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/cs_read_path.sv
module cs_read_path import chunk_stage_pkg::*; #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 18,
  parameter int CNT_W  = ADDR_W + 1,
  parameter int RD_LAT = 3,
  localparam int BEATS = DATA_W / SLICE_W,
  localparam int MEM_W = BEATS * BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              drain_i,
  input  logic [CNT_W-1:0]  target_i,
  output logic              mem_rd_en_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic [MEM_W-1:0]  mem_rd_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i,
  output logic              last_o
);
  localparam int DEPTH = RD_LAT + 2;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  rd_cnt_q, out_cnt_q;
  logic [RD_LAT-1:0] vld_sr_q;
  logic [DATA_W-1:0] buf_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [LVL_W-1:0]  lvl_q, inflight;
  logic [LVL_W:0]    occ;
  logic [DATA_W-1:0] strip_data;
  logic [BEATS*PAD_W-1:0] unused_pad_bits;
  logic push, pop, credit;

  for (genvar b = 0; b < BEATS; b++) begin : g_strip
    assign strip_data[b*SLICE_W +: SLICE_W] = mem_rd_data_i[b*BEAT_W +: SLICE_W];
    assign unused_pad_bits[b*PAD_W +: PAD_W] = mem_rd_data_i[b*BEAT_W+SLICE_W +: PAD_W];
  end

  always_comb begin
    inflight = '0;
    for (int i = 0; i < RD_LAT; i++) inflight = inflight + LVL_W'(vld_sr_q[i]);
  end

  // credit: buffered plus in-flight words must leave room for one more return
  assign occ           = {1'b0, lvl_q} + {1'b0, inflight};
  assign credit        = occ < (LVL_W+1)'(DEPTH);
  assign mem_rd_en_o   = drain_i && (rd_cnt_q < target_i) && credit;
  assign mem_rd_addr_o = rd_cnt_q[ADDR_W-1:0];

  assign push        = vld_sr_q[RD_LAT-1];
  assign out_valid_o = lvl_q != '0;
  assign out_data_o  = buf_q[rp_q];
  assign pop         = out_valid_o && out_ready_i;
  assign last_o      = pop && (out_cnt_q == target_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt_q  <= '0;
      out_cnt_q <= '0;
      vld_sr_q  <= '0;
    end else begin
      vld_sr_q[0] <= mem_rd_en_o;
      for (int i = 1; i < RD_LAT; i++) vld_sr_q[i] <= vld_sr_q[i-1];
      if (start_i) begin
        rd_cnt_q  <= '0;
        out_cnt_q <= '0;
      end else begin
        if (mem_rd_en_o) rd_cnt_q  <= rd_cnt_q + CNT_W'(1);
        if (pop)         out_cnt_q <= out_cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) buf_q[wp_q] <= strip_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push) wp_q <= (wp_q == PTR_W'(DEPTH-1)) ? '0 : wp_q + PTR_W'(1);
      if (pop)  rp_q <= (rp_q == PTR_W'(DEPTH-1)) ? '0 : rp_q + PTR_W'(1);
      case ({push, pop})
        2'b10:   lvl_q <= lvl_q + LVL_W'(1);
        2'b01:   lvl_q <= lvl_q - LVL_W'(1);
        default: lvl_q <= lvl_q;
      endcase
    end
  end
endmodule

// File: rtl/chunk_stage_ctrl.sv
module chunk_stage_ctrl import chunk_stage_pkg::*; #(
  parameter int DATA_W = 128,
  parameter int ADDR_W = 18,
  parameter int RD_LAT = 3,
  localparam int BYTES_W = ADDR_W + 4,
  localparam int CNT_W   = ADDR_W + 1,
  localparam int MEM_W   = (DATA_W / SLICE_W) * BEAT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [BYTES_W-1:0] cfg_bytes_i,
  input  logic               dummy_we_i,
  output logic               dummy_ack_o,
  output logic               idle_o,
  output logic               done_o,
  input  logic               in_valid_i,
  input  logic [DATA_W-1:0]  in_data_i,
  output logic               in_ready_o,
  output logic               mem_wr_en_o,
  output logic [ADDR_W-1:0]  mem_wr_addr_o,
  output logic [MEM_W-1:0]   mem_wr_data_o,
  output logic               mem_rd_en_o,
  output logic [ADDR_W-1:0]  mem_rd_addr_o,
  input  logic [MEM_W-1:0]   mem_rd_data_i,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  out_data_o,
  input  logic               out_ready_i
);
  cs_state_e        state_q, state_d;
  logic [CNT_W-1:0] target_q, target_d;
  logic [BYTES_W:0] round_sum;
  logic [3:0]       unused_frac;
  logic             start, wr_last, rd_last, dummy_ack_q;

  assign round_sum   = {1'b0, cfg_bytes_i} + (BYTES_W+1)'(15);
  assign target_d    = round_sum[BYTES_W:4];
  assign unused_frac = round_sum[3:0];
  assign start       = (state_q == ST_IDLE) && cfg_we_i && (cfg_bytes_i != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start)   state_d = ST_FILL;
      ST_FILL:  if (wr_last) state_d = ST_DRAIN;
      ST_DRAIN: if (rd_last) state_d = ST_DONE;
      ST_DONE:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      target_q    <= '0;
      dummy_ack_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      dummy_ack_q <= dummy_we_i;
      if (start) target_q <= target_d;
    end
  end

  assign idle_o      = state_q == ST_IDLE;
  assign done_o      = state_q == ST_DONE;
  assign dummy_ack_o = dummy_ack_q;

  cs_write_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_wr (
    .clk_i, .rst_ni,
    .start_i      (start),
    .fill_i       (state_q == ST_FILL),
    .target_i     (target_q),
    .in_valid_i, .in_data_i, .in_ready_o,
    .mem_wr_en_o, .mem_wr_addr_o, .mem_wr_data_o,
    .last_o       (wr_last)
  );

  cs_read_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_LAT(RD_LAT)) u_rd (
    .clk_i, .rst_ni,
    .start_i      (start),
    .drain_i      (state_q == ST_DRAIN),
    .target_i     (target_q),
    .mem_rd_en_o, .mem_rd_addr_o, .mem_rd_data_i,
    .out_valid_o, .out_data_o, .out_ready_i,
    .last_o       (rd_last)
  );
endmodule

// File: rtl/chunk_stage_ctrl_chk.sv
module chunk_stage_ctrl_chk #(
  parameter int DATA_W  = 128,
  parameter int ADDR_W  = 18,
  parameter int BYTES_W = ADDR_W + 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               cfg_we_i,
  input logic [BYTES_W-1:0] cfg_bytes_i,
  input logic               dummy_we_i,
  input logic               dummy_ack_o,
  input logic               idle_o,
  input logic               done_o,
  input logic               in_ready_o,
  input logic               mem_wr_en_o,
  input logic               mem_rd_en_o,
  input logic               out_valid_o,
  input logic [DATA_W-1:0]  out_data_o,
  input logic               out_ready_i
);
  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && cfg_we_i && (cfg_bytes_i != '0) |=> in_ready_o && !idle_o);

  p_no_out_in_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !out_valid_o && !mem_rd_en_o);

  p_rw_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_en_o && mem_rd_en_o));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && idle_o);

  p_dummy_ack_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dummy_we_i |=> dummy_ack_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> !mem_wr_en_o && !mem_rd_en_o && !in_ready_o);
endmodule

bind chunk_stage_ctrl chunk_stage_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_chunk_stage_ctrl.sv
module tb_chunk_stage_ctrl;
  localparam int DW = 128, AW = 18, LAT = 3, SKID = LAT + 2, MW = 144;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, dummy_we = 0, in_valid = 0, out_ready = 0;
  logic [AW+3:0] cfg_bytes = '0;
  logic [DW-1:0] in_data = '0;
  logic dummy_ack, idle, done, in_ready, wr_en, rd_en, out_valid;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [MW-1:0] wr_data, rd_data;
  logic [DW-1:0] out_data;

  always #10 clk = ~clk;

  chunk_stage_ctrl #(.DATA_W(DW), .ADDR_W(AW), .RD_LAT(LAT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_bytes_i(cfg_bytes),
    .dummy_we_i(dummy_we), .dummy_ack_o(dummy_ack), .idle_o(idle), .done_o(done),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .mem_wr_en_o(wr_en), .mem_wr_addr_o(wr_addr), .mem_wr_data_o(wr_data),
    .mem_rd_en_o(rd_en), .mem_rd_addr_o(rd_addr), .mem_rd_data_i(rd_data),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready));

  int total = 0, bad = 0;
  int wr_seen = 0, rd_seen = 0, wr_err = 0, rd_err = 0, exp_wr = 0, exp_rd = 0, cur_seed = 0;
  bit noisy = 0;
  logic [MW-1:0] mem [256];
  logic [MW-1:0] rd_pipe [LAT];
  logic [MW-1:0] pad_mask;

  function automatic logic [DW-1:0] mk_word(int s, int i);
    return {32'(s * 7 + i), 32'(i * 13 + 5), ~32'(i), 32'(s) ^ 32'(i << 4)};
  endfunction

  function automatic logic [MW-1:0] pad_of(logic [DW-1:0] w);
    logic [MW-1:0] m = '0;
    for (int b = 0; b < 4; b++) m[b*36 +: 32] = w[b*32 +: 32];
    return m;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  initial for (int b = 0; b < 4; b++) begin
    pad_mask = (b == 0) ? '0 : pad_mask;
    pad_mask[b*36+32 +: 4] = 4'hF;
  end

  // behavioural memory and bus monitor
  always @(posedge clk) begin
    if (wr_en) begin
      if (int'(wr_addr) != exp_wr || (wr_data & pad_mask) != '0 ||
          wr_data != pad_of(mk_word(cur_seed, exp_wr))) wr_err++;
      mem[wr_addr[7:0]] <= noisy ? (wr_data | pad_mask) : wr_data;
      exp_wr++;
      wr_seen++;
    end
    if (rd_en) begin
      if (int'(rd_addr) != exp_rd) rd_err++;
      exp_rd++;
      rd_seen++;
    end
    rd_pipe[0] <= rd_en ? mem[rd_addr[7:0]] : '0;
    for (int i = 1; i < LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
  end
  assign rd_data = rd_pipe[LAT-1];

  task automatic t_reset();
    @(negedge clk);
    chk(idle && !in_ready && !out_valid && !wr_en && !rd_en && !done && !dummy_ack,
        "R1", "outputs in reset", {done, dummy_ack, out_valid, in_ready, idle}, 1);
    rst_n = 1;
    @(negedge clk);
    chk(idle && !in_ready && !out_valid && !done, "R1", "outputs after reset",
        {done, out_valid, in_ready, idle}, 1);
  endtask

  task automatic t_idle_ignores();
    int w0 = wr_seen;
    cfg_we = 1; cfg_bytes = '0;
    @(negedge clk);
    cfg_we = 0;
    chk(idle && !in_ready, "R10", "zero byte count ignored", {in_ready, idle}, 2'b01);
    dummy_we = 1;
    @(negedge clk);
    dummy_we = 0;
    chk(dummy_ack == 1, "R9", "dummy ack in idle", dummy_ack, 1);
    @(negedge clk);
    chk(idle && !dummy_ack && wr_seen == w0 && rd_seen == 0, "R9", "dummy has no effect",
        {dummy_ack, idle}, 2'b01);
  endtask

  // stall: 0 none, 1 every third cycle, 2 long stall
  task automatic run_chunk(int bytes, int seed, int stall, bit nz, bit poke);
    int n = (bytes + 15) / 16;
    int k = 0, cyc = 0, mism = 0;
    logic [DW-1:0] first_act = '0, first_exp = '0;
    cur_seed = seed; noisy = nz;
    exp_wr = 0; exp_rd = 0; wr_seen = 0; rd_seen = 0; wr_err = 0; rd_err = 0;
    cfg_we = 1; cfg_bytes = (AW+4)'(bytes);
    @(negedge clk);
    cfg_we = 0;
    chk(in_ready && !idle, "R2", "chunk start", {in_ready, idle}, 2'b10);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = mk_word(seed, i);
      dummy_we = poke && (i == n / 2);
      cfg_we = poke && (i == 1); cfg_bytes = 22'd512;
      @(negedge clk);
      if (poke && i == n / 2) chk(dummy_ack == 1, "R9", "dummy ack during fill", dummy_ack, 1);
    end
    dummy_we = 0; cfg_we = 0;
    chk(!in_ready, "R4", "ready drops after last word", in_ready, 0);
    chk(wr_seen == n && wr_err == 0, "R3", "writes addr/padding", wr_seen, n);
    while (k < n && cyc < 5000) begin
      case (stall)
        0: out_ready = 1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = !(cyc >= 2 && cyc < 22);
      endcase
      dummy_we = poke && (cyc == 4);
      if (poke && cyc == 5) chk(dummy_ack == 1, "R9", "dummy ack during drain", dummy_ack, 1);
      if (stall == 2 && cyc == 21)
        chk(out_valid && rd_seen <= k + SKID, "R7", "stall bounds reads", rd_seen, k + SKID);
      if (out_valid && out_ready) begin
        if (out_data != mk_word(seed, k) && mism == 0) begin
          first_act = out_data; first_exp = mk_word(seed, k);
        end
        if (out_data != mk_word(seed, k)) mism++;
        k++;
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 0; dummy_we = 0; in_valid = 1;
    chk(mism == 0, "R6", "output words", first_act, first_exp);
    chk(k == n, "R7", "word count delivered", k, n);
    chk(done == 1 && !idle, "R8", "done pulse", {done, idle}, 2'b10);
    @(negedge clk);
    chk(!done && idle, "R8", "back to idle", {done, idle}, 2'b01);
    chk(rd_seen == n && rd_err == 0, "R5", "read sequence", rd_seen, n);
    chk(wr_seen == n, "R4", "no writes after fill", wr_seen, n);
    in_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_idle_ignores();
    run_chunk(16, 1, 0, 0, 0);
    run_chunk(17, 2, 1, 0, 0);
    run_chunk(100, 3, 2, 1, 1);
    run_chunk(4000, 4, 1, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule